// File: doc/BRIEF.md
# SPI Bit-Clock Tick Generator

This block turns the system clock into a stream of single-cycle enable pulses for an SPI serial engine. Each pulse marks one half period of the serial clock. The engine toggles its clock line on every pulse and so produces a symmetric waveform. The rate is set in two stages. A 3-bit coarse select picks one of eight prescale factors, which are not evenly spaced. A 4-bit fine divider then multiplies that factor by 1 to 16. A fast-mode input replaces the coarse factor with 1 and leaves the fine divider in force.

The counter runs only while the module is enabled and the engine reports that a transfer is in progress. The counter returns to zero whenever either input drops, and also whenever any rate setting changes. As a result, the first pulse after a start or a reconfiguration always follows a full half period. The block does not form the serial clock waveform itself.

Top module: `spi_rate_gen`

## Requirements
- R1: After reset, `tick` is low, and it stays low until a half period has been counted.
- R2: Coarse select codes 0,1,2,3,4,5,6,7 give prescale factors 2,4,8,64,128,1024,2048,4096. While running, consecutive ticks are exactly prescale × (1 + `fdiv`) clock cycles apart.
- R3: The 4-bit `fdiv` value N multiplies the half period by N+1, so values 0 to 15 give factors 1 to 16.
- R4: When `fast` is high, the prescale factor is 1. With `fdiv`=0, `tick` is high on every cycle while running.
- R5: Without `fast`, the shortest half period is 2 cycles (select 0, `fdiv` 0) and the longest is 65536 cycles (select 7, `fdiv` 15).
- R6: If `en` and `busy` are first sampled high together at clock edge k, the first tick is high after edge k+P-1, where P is the half period. The same count applies after every restart from idle.
- R7: If any of `fast`, `psel` or `fdiv` changes while running, the edge that first samples the new value clears the count, and no tick follows that edge. If that edge is k, the first tick under the new setting is high after edge k+P.
- R8: While `en` is low, no tick is produced and the count is held at zero. Re-enabling starts a full half period, timed as in R6.
- R9: While `busy` is low, no tick is produced and the count is held at zero. Raising `busy` again starts a full half period.
- R10: When P is greater than 1, each tick lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Module enable. Low clears and holds the counter |
| busy | input | 1 | Engine transfer in progress. Low clears and holds the counter |
| fast | input | 1 | Forces the coarse prescale factor to 1 |
| psel | input | 3 | Coarse prescale select |
| fdiv | input | DIV_W (4) | Fine divider value N, which divides by N+1 |
| tick | output | 1 | Single-cycle half-period enable |

## Verification
Let P be the half period. A tick is due P cycles after `busy` or `en` is first sampled high, and P+1 cycles after a rate change is first sampled while running. Both counts include the registered `tick` output. The driver changes inputs only on falling edges. Whenever it changes an input, it records the cycle number in which each coming pulse is due and discards predictions that the change has cancelled. The monitor samples 2 ns after each rising edge and matches `tick` against the prediction for that exact cycle. Any pulse that was not predicted is counted as a failure, and so is any predicted pulse that does not appear.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;

  // Width of the coarse select code and of the largest coarse factor
  localparam int SEL_W = 3;
  localparam int PSC_W = 13;

  // Coarse prescale factor. Fast mode overrides the table with 1.
  function automatic logic [PSC_W-1:0] coarse_factor(input logic [SEL_W-1:0] sel,
                                                      input logic fast_mode);
    logic [PSC_W-1:0] f;
    if (fast_mode) begin
      f = PSC_W'(1);
    end else begin
      case (sel)
        3'd0:    f = PSC_W'(2);
        3'd1:    f = PSC_W'(4);
        3'd2:    f = PSC_W'(8);
        3'd3:    f = PSC_W'(64);
        3'd4:    f = PSC_W'(128);
        3'd5:    f = PSC_W'(1024);
        3'd6:    f = PSC_W'(2048);
        default: f = PSC_W'(4096);
      endcase
    end
    return f;
  endfunction

endpackage

// File: rtl/spi_rate_cfg.sv
module spi_rate_cfg #(
  parameter int DIV_W = 4,
  localparam int CNT_W = spi_rate_pkg::PSC_W + DIV_W,
  localparam int CFG_W = spi_rate_pkg::SEL_W + DIV_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fast,
  input  logic [spi_rate_pkg::SEL_W-1:0] psel,
  input  logic [DIV_W-1:0]              fdiv,
  output logic [CNT_W-1:0]              period,
  output logic                          cfg_chg
);
  import spi_rate_pkg::*;

  logic [CFG_W-1:0] cfg_now;
  logic [CFG_W-1:0] cfg_q;
  logic [DIV_W:0]   fine_mult;

  assign cfg_now   = {fast, psel, fdiv};
  assign fine_mult = {1'b0, fdiv} + 1'b1;
  assign period    = CNT_W'(coarse_factor(psel, fast)) * CNT_W'(fine_mult);

  // Snapshot of the settings seen at the previous edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_now;
  end

  assign cfg_chg = (cfg_now != cfg_q);

endmodule

// File: rtl/spi_rate_cnt.sv
module spi_rate_cnt #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             tick
);

  assign wrap = (cnt == period - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (!run || restart) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CNT_W'(1);
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int DIV_W = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           en,
  input  logic                           busy,
  input  logic                           fast,
  input  logic [spi_rate_pkg::SEL_W-1:0] psel,
  input  logic [DIV_W-1:0]               fdiv,
  output logic                           tick
);
  localparam int CNT_W = spi_rate_pkg::PSC_W + DIV_W;

  // Named internal events, also used by the checker
  logic             run;
  logic             cfg_chg;
  logic             wrap;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] cnt;

  assign run = en & busy;

  spi_rate_cfg #(.DIV_W(DIV_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .fast    (fast),
    .psel    (psel),
    .fdiv    (fdiv),
    .period  (period),
    .cfg_chg (cfg_chg)
  );

  spi_rate_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (cfg_chg),
    .period  (period),
    .cnt     (cnt),
    .wrap    (wrap),
    .tick    (tick)
  );

endmodule

// File: rtl/spi_rate_gen_chk.sv
module spi_rate_gen_chk #(
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             fast,
  input logic             restart,
  input logic             wrap,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] cnt,
  input logic             tick
);

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period != CNT_W'(1)) |=> !tick);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!tick && cnt == '0));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && restart) |=> (!tick && cnt == '0));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (cnt < period));

  // R2
  tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ($past(wrap) && $past(run)));

  // R5
  slow_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fast |-> (period >= CNT_W'(2)));

endmodule

bind spi_rate_gen spi_rate_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run),
  .fast    (fast),
  .restart (cfg_chg),
  .wrap    (wrap),
  .period  (period),
  .cnt     (cnt),
  .tick    (tick)
);

// File: tb/sim_spi_rate_gen.sv
`timescale 1ns/1ps
module sim_spi_rate_gen;

  typedef struct {
    int    at;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       busy = 1'b0;
  logic       fast = 1'b0;
  logic [2:0] psel = 3'd0;
  logic [3:0] fdiv = 4'd0;
  logic       tick;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  exp_t sb[$];

  spi_rate_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .busy(busy),
    .fast(fast), .psel(psel), .fdiv(fdiv), .tick(tick)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Expected half period, written from the requirement table
  function automatic int half_period(bit f, int sel, int dv);
    int tbl [8] = '{2, 4, 8, 64, 128, 1024, 2048, 4096};
    return (f ? 1 : tbl[sel]) * (dv + 1);
  endfunction

  // Monitor: compares tick with the scoreboard in each cycle
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      while (sb.size() > 0 && sb[0].at < cyc) begin
        n_chk++; n_fail++;
        $display("FAIL %s: tick missing at cycle %0d, actual 0 expected 1", sb[0].tag, sb[0].at);
        void'(sb.pop_front());
      end
      if (sb.size() > 0 && sb[0].at == cyc) begin
        n_chk++;
        if (tick !== 1'b1) begin
          n_fail++;
          $display("FAIL %s: cycle %0d actual %b expected 1", sb[0].tag, cyc, tick);
        end
        void'(sb.pop_front());
      end else if (tick !== 1'b0) begin
        n_chk++; n_fail++;
        $display("FAIL R10/R9: unexpected tick at cycle %0d, actual %b expected 0", cyc, tick);
      end
    end
  end

  task automatic expect_ticks(int base, int per, int n, string tag);
    for (int i = 1; i <= n; i++) begin
      exp_t e;
      e.at  = base + per * i;
      e.tag = (i == 1) ? {tag, "/R6"} : tag;
      sb.push_back(e);
    end
  endtask

  task automatic flush_future();
    while (sb.size() > 0 && sb[$].at > cyc) void'(sb.pop_back());
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  // Driver: configure while idle, start, predict ticks, wait for them
  task automatic run_case(bit f, int sel, int dv, int n, string tag);
    @(negedge clk);
    busy = 1'b0; fast = f; psel = 3'(sel); fdiv = 4'(dv);
    repeat (2) @(negedge clk);
    busy = 1'b1;
    expect_ticks(cyc, half_period(f, sel, dv), n, tag);
    drain();
    busy = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1;
    repeat (3) @(negedge clk);
    // R1: tick low after reset while idle
    n_chk++;
    if (tick !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: actual %b expected 0", tick);
    end

    // R2: every coarse code
    for (int s = 0; s < 8; s++) run_case(1'b0, s, 0, 2, "R2");
    // R3: fine divider values
    run_case(1'b0, 0, 1, 3, "R3");
    run_case(1'b0, 0, 7, 3, "R3");
    run_case(1'b0, 1, 15, 2, "R3");
    // R4: fast mode
    run_case(1'b1, 6, 0, 5, "R4");
    run_case(1'b1, 2, 3, 3, "R4");
    run_case(1'b1, 7, 15, 2, "R4");
    // R5: fastest and slowest without fast mode
    run_case(1'b0, 0, 0, 4, "R5");
    run_case(1'b0, 7, 15, 1, "R5");

    // R7: change the rate while running
    begin
      int c0;
      @(negedge clk);
      fast = 1'b0; psel = 3'd1; fdiv = 4'd0;
      repeat (2) @(negedge clk);
      busy = 1'b1; c0 = cyc;
      expect_ticks(c0, 4, 5, "R7");
      repeat (6) @(negedge clk);
      psel = 3'd0; fdiv = 4'd2;
      flush_future();
      expect_ticks(cyc + 1, 6, 3, "R7");
      drain();
      busy = 1'b0;
    end

    // R8: drop enable mid-period
    @(negedge clk);
    psel = 3'd2; fdiv = 4'd0;
    repeat (2) @(negedge clk);
    busy = 1'b1;
    expect_ticks(cyc, 8, 3, "R8");
    repeat (11) @(negedge clk);
    en = 1'b0;
    flush_future();
    repeat (5) @(negedge clk);
    en = 1'b1;
    expect_ticks(cyc, 8, 2, "R8");
    drain();
    busy = 1'b0;

    // R9: drop busy mid-period
    @(negedge clk);
    busy = 1'b1;
    expect_ticks(cyc, 8, 3, "R9");
    repeat (13) @(negedge clk);
    busy = 1'b0;
    flush_future();
    repeat (20) @(negedge clk);
    busy = 1'b1;
    expect_ticks(cyc, 8, 2, "R9");
    drain();
    busy = 1'b0;

    repeat (10) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule